// File: doc/BRIEF.md
# Serial Display Command/Data Byte Receiver

This block sits between a host's three- or four-wire synchronous serial link and the command decoder of a display controller. The host drives an active-low chip select, a serial clock and a data line. The host may also drive a register-select line. The block assembles each group of eight clock rises into a byte. It then marks the byte as either a controller command or a byte of display data.

The `rs_mode` input picks how that mark is made. When `rs_mode` is high, the register-select line, sampled together with the last bit, gives the mark. When `rs_mode` is low, no register-select line is used and every byte counts as a command. The one exception is a data window opened by a fixed escape command followed by a length byte. The window delivers a counted run of data bytes and then closes by itself.

For each byte the block gives a one-cycle valid strobe, the byte value and the command/data flag. For each display-data byte it also gives a pulse that advances the column address. All serial inputs pass through a synchroniser into the system clock domain. The system clock must run at least four times as fast as the serial clock.

Top module: `serial_cmd_rx`

## Requirements
- R1: While `cs_n` is high, the bit counter and shift register are held cleared and `sclk`/`sdata` produce no byte. Bits of a byte left incomplete when `cs_n` rose are discarded, so the next byte after `cs_n` falls is framed from its first bit.
- R2: `sdata` is sampled on rising `sclk`, most significant bit first. On the eighth rise, `byte_valid` pulses for exactly one cycle with the assembled byte on `byte_out`. The pulse is visible in the cycle after the fourth rising `clk` edge following the `sclk` rise.
- R3: With `rs_mode` = 1, `is_data` equals the level of `rs` at the eighth `sclk` rise: 1 means display data, 0 means command.
- R4: With `rs_mode` = 0, every byte is reported with `is_data` = 0 unless a data window is open. The `rs` input is ignored in this mode.
- R5: With `rs_mode` = 0, the byte 0xE8 followed by a length byte N opens a window of N+1 display-data bytes. Both the 0xE8 byte and the length byte are themselves reported as commands. A 0xE8 byte inside the window is data.
- R6: The first byte after the last byte of the window is reported as a command.
- R7: `col_inc` pulses exactly once for each byte reported with `is_data` = 1, in the same cycle as its `byte_valid`, and never for a command byte.
- R8: If `cs_n` rises during a byte or during a window, the transfer is abandoned. After `cs_n` falls again, the next byte is a command.
- R9: A length byte above 127 opens a window of exactly 128 data bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs_mode | input | 1 | 1: register-select line marks data; 0: escape/length window marks data |
| cs_n | input | 1 | Active-low chip select from host |
| sclk | input | 1 | Serial clock from host |
| sdata | input | 1 | Serial data, MSB first |
| rs | input | 1 | Register select, high for display data (used when rs_mode = 1) |
| byte_valid | output | 1 | One-cycle strobe for each received byte |
| byte_out | output | 8 | Received byte, held until the next strobe |
| is_data | output | 1 | 1 = display data, 0 = command, for the current byte |
| col_inc | output | 1 | Column-address advance pulse for display-data bytes |

## Verification
A byte's strobe, value, flag and column pulse are all due in the cycle after the fourth rising `clk` edge that follows the eighth `sclk` rise. The path is two synchroniser flops, the shifter register and the output register. The bench drives every input at a falling `clk` edge and records the cycle count of each `sclk` rise. A monitor at falling edges logs every strobe with its cycle number. Each check compares a logged entry against the expected byte, flag and column pulse, and requires a latency of exactly four cycles. Each check reads its entry two cycles after the strobe is due, and confirms that no extra strobe has appeared, which covers the cases where `cs_n` is high or a byte is incomplete.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

   typedef enum logic [1:0] {
      ST_CMD  = 2'd0,
      ST_LEN  = 2'd1,
      ST_DATA = 2'd2
   } rx_state_e;

endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
   parameter int              W       = 4,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdr_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("sdr_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sdr_shifter.sv
module sdr_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              rs_s,
   output logic              byte_stb,
   output logic [BYTE_W-1:0] byte_q,
   output logic              byte_rs
);

   localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_byte
         $error("sdr_shifter: BYTE_W must be at least 2");
      end
   endgenerate

   logic                sclk_prev;
   logic                sclk_rise;
   logic [BIT_W-1:0]    bit_cnt;
   logic [BYTE_W-2:0]   shreg;
   logic [BYTE_W-1:0]   shift_next;

   assign sclk_rise  = sclk_s & ~sclk_prev;
   assign shift_next = {shreg, sdat_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
      end else begin
         sclk_prev <= sclk_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         byte_stb <= 1'b0;
         byte_q   <= '0;
         byte_rs  <= 1'b0;
      end else if (!cs_act) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         byte_stb <= 1'b0;
      end else begin
         byte_stb <= 1'b0;
         if (sclk_rise) begin
            shreg <= shift_next[BYTE_W-2:0];
            if (bit_cnt == LAST_BIT) begin
               bit_cnt  <= '0;
               byte_stb <= 1'b1;
               byte_q   <= shift_next;
               byte_rs  <= rs_s;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   // R1: an idle select clears the framing and blocks any byte
   assert_cs_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (bit_cnt == '0) && !byte_stb);

   // R2: a byte strobe never lasts longer than one cycle
   assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb |=> !byte_stb);

endmodule

// File: rtl/sdr_classifier.sv
module sdr_classifier
   import sdr_pkg::*;
#(
   parameter int                BYTE_W   = 8,
   parameter logic [BYTE_W-1:0] ESC_CODE = 8'hE8,
   parameter int                MAX_RUN  = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              rs_mode,
   input  logic              in_stb,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_rs,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_out,
   output logic              is_data,
   output logic              col_inc
);

   localparam int RUN_W = (MAX_RUN > 1) ? $clog2(MAX_RUN) : 1;
   localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(MAX_RUN - 1);

   generate
      if (MAX_RUN < 1) begin : g_bad_run
         $error("sdr_classifier: MAX_RUN must be positive");
      end
      if (RUN_W > BYTE_W) begin : g_bad_run_w
         $error("sdr_classifier: MAX_RUN exceeds the length byte range");
      end
   endgenerate

   rx_state_e        state;
   logic [RUN_W-1:0] remain;
   logic [RUN_W-1:0] len_sat;

   always_comb begin
      if (int'(in_byte) > MAX_RUN - 1) len_sat = RUN_TOP;
      else                             len_sat = in_byte[RUN_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_CMD;
         remain     <= '0;
         byte_valid <= 1'b0;
         byte_out   <= '0;
         is_data    <= 1'b0;
         col_inc    <= 1'b0;
      end else if (!cs_act) begin
         state      <= ST_CMD;
         remain     <= '0;
         byte_valid <= 1'b0;
         col_inc    <= 1'b0;
      end else begin
         byte_valid <= 1'b0;
         col_inc    <= 1'b0;
         if (in_stb) begin
            byte_valid <= 1'b1;
            byte_out   <= in_byte;
            if (rs_mode) begin
               is_data <= in_rs;
               col_inc <= in_rs;
               state   <= ST_CMD;
            end else begin
               case (state)
                  ST_CMD: begin
                     is_data <= 1'b0;
                     if (in_byte == ESC_CODE) state <= ST_LEN;
                  end
                  ST_LEN: begin
                     is_data <= 1'b0;
                     remain  <= len_sat;
                     state   <= ST_DATA;
                  end
                  ST_DATA: begin
                     is_data <= 1'b1;
                     col_inc <= 1'b1;
                     if (remain == '0) state <= ST_CMD;
                     else              remain <= remain - 1'b1;
                  end
                  default: begin
                     is_data <= 1'b0;
                     state   <= ST_CMD;
                  end
               endcase
            end
         end
      end
   end

   // R3: the register-select level decides the flag in pin mode
   assert_pin_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_stb && cs_act && rs_mode) |=> byte_valid && (is_data == $past(in_rs)));

   // R4: a byte arriving in the idle command state is a command
   assert_default_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_stb && cs_act && !rs_mode && state == ST_CMD) |=> byte_valid && !is_data);

   // R7: column pulse only with a display-data strobe
   assert_col_inc_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      col_inc |-> (byte_valid && is_data));

   // R8: select release abandons everything
   assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (state == ST_CMD) && !byte_valid);

   // R9: a loaded window never exceeds the run limit
   assert_run_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_stb && cs_act && !rs_mode && state == ST_LEN) |=> (state == ST_DATA) && (remain <= RUN_TOP));

endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx #(
   parameter int                BYTE_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [BYTE_W-1:0] ESC_CODE    = 8'hE8,
   parameter int                MAX_RUN     = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rs_mode,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdata,
   input  logic              rs,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_out,
   output logic              is_data,
   output logic              col_inc
);

   localparam int IN_W = 4;
   localparam logic [IN_W-1:0] IN_RST = 4'b1000;

   logic [IN_W-1:0]   raw_in;
   logic [IN_W-1:0]   sync_in;
   logic              cs_act;
   logic              stb;
   logic [BYTE_W-1:0] sh_byte;
   logic              sh_rs;

   assign raw_in = {cs_n, sclk, sdata, rs};
   assign cs_act = ~sync_in[3];

   sdr_sync #(
      .W       (IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_in)
   );

   sdr_shifter #(
      .BYTE_W (BYTE_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .sclk_s   (sync_in[2]),
      .sdat_s   (sync_in[1]),
      .rs_s     (sync_in[0]),
      .byte_stb (stb),
      .byte_q   (sh_byte),
      .byte_rs  (sh_rs)
   );

   sdr_classifier #(
      .BYTE_W   (BYTE_W),
      .ESC_CODE (ESC_CODE),
      .MAX_RUN  (MAX_RUN)
   ) u_class (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .rs_mode    (rs_mode),
      .in_stb     (stb),
      .in_byte    (sh_byte),
      .in_rs      (sh_rs),
      .byte_valid (byte_valid),
      .byte_out   (byte_out),
      .is_data    (is_data),
      .col_inc    (col_inc)
   );

endmodule

// File: tb/sim_serial_cmd_rx.sv
module sim_serial_cmd_rx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rs_mode = 1'b1;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdata = 1'b0;
   logic       rs = 1'b0;
   logic       byte_valid;
   logic [7:0] byte_out;
   logic       is_data;
   logic       col_inc;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int t_last = 0;
   int nlog = 0;
   int rp = 0;
   logic [7:0] logb [2048];
   logic       logd [2048];
   logic       logc [2048];
   int         logt [2048];

   always #4 clk = ~clk;

   serial_cmd_rx u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .rs_mode    (rs_mode),
      .cs_n       (cs_n),
      .sclk       (sclk),
      .sdata      (sdata),
      .rs         (rs),
      .byte_valid (byte_valid),
      .byte_out   (byte_out),
      .is_data    (is_data),
      .col_inc    (col_inc)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && byte_valid && nlog < 2048) begin
         logb[nlog] = byte_out;
         logd[nlog] = is_data;
         logc[nlog] = col_inc;
         logt[nlog] = cyc;
         nlog = nlog + 1;
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         sdata = b[7-i];
         sclk  = 1'b0;
         wait_n(4);
         sclk   = 1'b1;
         t_last = cyc;
         wait_n(4);
      end
      sclk = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b, input logic r);
      rs = r;
      send_bits(b, 8);
   endtask

   task automatic cs_low();
      cs_n = 1'b0;
      wait_n(4);
   endtask

   task automatic cs_high();
      cs_n = 1'b1;
      wait_n(4);
   endtask

   task automatic expect_byte(input logic [7:0] b, input logic d, input string tag);
      wait_n(2);
      tests++;
      if (nlog <= rp) begin
         fails++;
         $display("FAIL %s: no byte strobe, expected byte %02h data %0b", tag, b, d);
      end else begin
         if (logb[rp] !== b || logd[rp] !== d || logc[rp] !== d || (logt[rp] - t_last) != 4) begin
            fails++;
            $display("FAIL %s: got byte %02h data %0b inc %0b latency %0d, expected byte %02h data %0b inc %0b latency 4",
                     tag, logb[rp], logd[rp], logc[rp], logt[rp] - t_last, b, d, d);
         end
         rp++;
      end
   endtask

   task automatic expect_none(input string tag);
      wait_n(2);
      tests++;
      if (nlog != rp) begin
         fails++;
         $display("FAIL %s: got %0d extra byte strobes, expected 0", tag, nlog - rp);
         rp = nlog;
      end
   endtask

   task automatic window_case(input int n);
      int k;
      logic [7:0] v;
      k = (n > 127) ? 128 : n + 1;
      send_byte(8'h12, 1'b1);
      expect_byte(8'h12, 1'b0, "R4 default command");
      send_byte(8'hE8, 1'b0);
      expect_byte(8'hE8, 1'b0, "R5 escape is command");
      send_byte(8'(n), 1'b0);
      expect_byte(8'(n), 1'b0, "R5 length is command");
      for (int j = 0; j < k; j++) begin
         v = (j == 1) ? 8'hE8 : 8'((j * 7 + n) & 255);
         send_byte(v, j[0]);
         expect_byte(v, 1'b1, (n > 127) ? "R9 saturated window data" : "R5 window data");
      end
      send_byte(8'h5A, 1'b1);
      expect_byte(8'h5A, 1'b0, "R6 command after window");
      expect_none("R9 window length");
   endtask

   initial begin
      wait_n(5);
      tests++;
      if (byte_valid !== 1'b0 || is_data !== 1'b0 || col_inc !== 1'b0) begin
         fails++;
         $display("FAIL R2 reset: got valid %0b data %0b inc %0b, expected 0 0 0", byte_valid, is_data, col_inc);
      end
      rst_n = 1'b1;
      wait_n(3);

      rs_mode = 1'b1;
      cs_low();
      for (int v = 0; v < 256; v++) begin
         send_byte(8'(v), v[0] ^ v[3]);
         expect_byte(8'(v), v[0] ^ v[3], "R2 R3 R7 pin-mode sweep");
      end
      cs_high();

      for (int i = 0; i < 5; i++) begin
         sdata = i[0];
         sclk = 1'b1; wait_n(4);
         sclk = 1'b0; wait_n(4);
      end
      expect_none("R1 select high ignored");
      cs_low();
      send_bits(8'hA5, 3);
      cs_high();
      expect_none("R1 partial byte");
      cs_low();
      send_byte(8'h3C, 1'b1);
      expect_byte(8'h3C, 1'b1, "R1 fresh framing");
      expect_none("R1 no extra");
      cs_high();

      rs_mode = 1'b0;
      cs_low();
      window_case(0);
      window_case(1);
      window_case(5);
      window_case(127);
      window_case(128);
      window_case(200);
      window_case(255);

      send_byte(8'hE8, 1'b0);
      expect_byte(8'hE8, 1'b0, "R8 escape");
      send_byte(8'h09, 1'b0);
      expect_byte(8'h09, 1'b0, "R8 length");
      send_byte(8'h81, 1'b0);
      expect_byte(8'h81, 1'b1, "R8 data before abort");
      send_byte(8'h82, 1'b0);
      expect_byte(8'h82, 1'b1, "R8 data before abort");
      cs_high();
      cs_low();
      send_byte(8'h44, 1'b1);
      expect_byte(8'h44, 1'b0, "R8 command after abort");

      send_byte(8'hE8, 1'b0);
      expect_byte(8'hE8, 1'b0, "R8 escape");
      send_byte(8'h03, 1'b0);
      expect_byte(8'h03, 1'b0, "R8 length");
      send_bits(8'hF0, 4);
      cs_high();
      expect_none("R8 mid-byte abort");
      cs_low();
      send_byte(8'h77, 1'b1);
      expect_byte(8'h77, 1'b0, "R8 command after mid-byte abort");
      expect_none("R8 no extra");
      cs_high();

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule